// File: doc/BRIEF.md
# Four-Mode SPI Master with Slave Selects

This block is a full-duplex serial master for a shared clock-and-data bus. A single start request carries everything that one transfer needs: the word to send, the index of the target slave, the clock mode (idle polarity and sampling phase) and a clock divider. The block then pulls that slave's active-low select line, toggles the serial clock, and shifts the word out most significant bit first. At the same time it captures a word of the same width from the shared input line. When the select releases it presents the received word with a one-cycle completion pulse.

A transfer carries only data bits, with no framing or check bits. Each serial clock half-period lasts (divider + 1) system clocks, and a divider of zero is treated as one. A state machine with four states steers the transfer:
- `ST_IDLE` waits for `start` (IDLE→LEAD on an accepted start).
- `ST_LEAD` holds the select low for one half-period before the first clock edge (LEAD→SHIFT on the first edge).
- `ST_SHIFT` produces the remaining clock edges (SHIFT→TRAIL after the last edge).
- `ST_TRAIL` waits one half-period, then releases the select and signals completion (TRAIL→IDLE).

Top module: `spi_quad_master`

## Requirements
- R1: After reset all select lines are high, `sclk` is low, `done` is low and `rx_byte` is zero.
- R2: `mode[1]` is the clock idle level (CPOL). `sclk` takes this level in the same cycle the select goes low, and keeps it after the transfer ends until the next accepted start.
- R3: With `mode[0]` = 0 (CPHA 0), the first data bit is on `mosi` as soon as the select goes low. Input is sampled on the odd-numbered clock edges (1st, 3rd, …) and `mosi` changes only on the even-numbered edges. In modes 0 and 2 this means: sample on the rising edge and shift on the falling edge for CPOL 0, and the reverse for CPOL 1.
- R4: With `mode[0]` = 1 (CPHA 1), `mosi` changes on the odd-numbered edges and input is sampled on the even-numbered edges. In modes 1 and 3 this means: shift on the rising edge and sample on the falling edge for CPOL 0, and the reverse for CPOL 1.
- R5: `tx_byte` leaves MSB first. The word sampled from `miso` (first sample into the MSB) appears on `rx_byte`.
- R6: During a transfer exactly one select is low: bit `slave_idx` of `ss_n`. All select lines are high when the block is idle.
- R7: A half-period is H = `divider` + 1 clocks (H = 2 for `divider` 0). The first edge comes H clocks after the select falls, consecutive edges are H clocks apart, and the select rises H clocks after the last edge.
- R8: `done` is high for exactly one cycle, in the cycle the select rises. `rx_byte` is valid then and holds until the next completion.
- R9: `start` is ignored while a transfer is running.
- R10: A transfer has exactly 16 clock edges for an 8-bit word, with no extra framing bits.
- R11: Mode, index, divider and transmit word are captured at the accepted start. Changes to these inputs during a transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, accepted only when idle |
| tx_byte | input | W | Word to transmit |
| slave_idx | input | IDX_W | Index of the select line to drive low |
| mode | input | 2 | [1] = idle clock level, [0] = sampling phase |
| divider | input | DIV_W | Half-period length minus one |
| miso | input | 1 | Shared serial input from the slaves |
| rx_byte | output | W | Last received word |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the slaves |
| ss_n | output | NSEL | Active-low slave selects |

## Verification
A wrong state or a miscounted edge shows at the pins within one half-period. A stray or missing `sclk` toggle shifts the edge spacing or the edge count, and a late or early state change moves the select rise away from exactly H clocks after the last edge. An off-by-one in the phase choice shows as a corrupted word on both sides at completion. A select decode or latch fault shows as a wrong or extra low line in the first cycle of the transfer. The bench plays the slave and times every edge against the select, so each of these faults is caught in the transfer where it occurs.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spim_state_e;

endpackage

// File: rtl/spim_halfper.sv
module spim_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R7: the half-period counter never runs past the latched divider
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));

endmodule

// File: rtl/spim_shreg.sv
module spim_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_out,
    input  logic         sample_in,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_val;
        else if (shift_out)
            tx_q <= {tx_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else if (load)
            rx_q <= '0;
        else if (sample_in)
            rx_q <= {rx_q[W-2:0], miso};
    end

    assign mosi    = tx_q[W-1];
    assign rx_word = rx_q;

    // R3 R4: one serial edge never both launches and captures
    assert_no_dual_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_out && sample_in));

endmodule

// File: rtl/spim_seldec.sv
module spim_seldec #(
    parameter int NSEL  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clr,
    input  logic [IDX_W-1:0] idx,
    output logic [NSEL-1:0]  ss_n
);

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_line
            logic line_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    line_q <= 1'b1;
                else if (set)
                    line_q <= (idx != IDX_W'(g));
                else if (clr)
                    line_q <= 1'b1;
            end
            assign ss_n[g] = line_q;
        end
    endgenerate

    // R6: never more than one select low
    assert_ss_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ss_n) <= 1);

endmodule

// File: rtl/spi_quad_master.sv
module spi_quad_master #(
    parameter int W     = 8,
    parameter int NSEL  = 4,
    parameter int DIV_W = 8,
    parameter int IDX_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     tx_byte,
    input  logic [IDX_W-1:0] slave_idx,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] divider,
    input  logic             miso,
    output logic [W-1:0]     rx_byte,
    output logic             done,
    output logic             sclk,
    output logic             mosi,
    output logic [NSEL-1:0]  ss_n
);
    import spim_pkg::*;

    localparam int EC_W = $clog2(2 * W + 1);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * W);

    spim_state_e st_q, st_d;

    logic             cpol_q, cpha_q;
    logic [DIV_W-1:0] div_q;
    logic [EC_W-1:0]  ecnt_q;
    logic [EC_W-1:0]  edge_no;
    logic             tick, accept, edge_fire, lead_edge;
    logic             shift_en, sample_en, finish;
    logic [W-1:0]     rx_word;

    assign accept    = (st_q == ST_IDLE) && start;
    assign edge_fire = tick && ((st_q == ST_LEAD) || (st_q == ST_SHIFT));
    assign edge_no   = ecnt_q + 1'b1;
    assign lead_edge = edge_no[0];
    assign finish    = tick && (st_q == ST_TRAIL);

    // Launch on trailing edges (CPHA 0) or on leading edges after the first (CPHA 1)
    assign shift_en  = edge_fire && (cpha_q ? (lead_edge && edge_no != EC_W'(1))
                                            : (!lead_edge && edge_no != LAST_EDGE));
    assign sample_en = edge_fire && (cpha_q ? !lead_edge : lead_edge);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_LEAD;
            ST_LEAD:  if (tick) st_d = ST_SHIFT;
            ST_SHIFT: if (tick && edge_no == LAST_EDGE) st_d = ST_TRAIL;
            ST_TRAIL: if (tick) st_d = ST_IDLE;
        endcase
    end

    // Outputs and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            div_q   <= DIV_W'(1);
            ecnt_q  <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                cpol_q <= mode[1];
                cpha_q <= mode[0];
                div_q  <= (divider == '0) ? DIV_W'(1) : divider;
                ecnt_q <= '0;
                sclk   <= mode[1];
            end else if (edge_fire) begin
                sclk   <= ~sclk;
                ecnt_q <= edge_no;
            end else if (finish) begin
                done    <= 1'b1;
                rx_byte <= rx_word;
            end
        end
    end

    spim_halfper #(.DIV_W(DIV_W)) u_halfper (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q != ST_IDLE),
        .div   (div_q),
        .tick  (tick)
    );

    spim_shreg #(.W(W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (tx_byte),
        .shift_out (shift_en),
        .sample_in (sample_en),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    spim_seldec #(.NSEL(NSEL), .IDX_W(IDX_W)) u_seldec (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (accept),
        .clr   (finish),
        .idx   (slave_idx),
        .ss_n  (ss_n)
    );

    // R2: clock rests at the latched idle level whenever no transfer runs
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (sclk == cpol_q));

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3 R4: inside a transfer the data line moves only together with the clock
    assert_mosi_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && $past(st_q) != ST_IDLE && mosi != $past(mosi))
            |-> (sclk != $past(sclk)));

    // R6: a select is low exactly while a transfer runs
    assert_ss_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) == (ss_n != {NSEL{1'b1}}));

    // R11: selects do not move in the middle of the shifting phase
    assert_ss_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT) |-> $stable(ss_n));

endmodule

// File: tb/sim_spi_quad_master.sv
module sim_spi_quad_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [1:0] slave_idx = '0;
    logic [1:0] mode = '0;
    logic [7:0] divider = '0;
    logic       miso = 1'b0;
    logic [7:0] rx_byte;
    logic       done;
    logic       sclk;
    logic       mosi;
    logic [3:0] ss_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    spi_quad_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .slave_idx(slave_idx), .mode(mode), .divider(divider), .miso(miso),
        .rx_byte(rx_byte), .done(done), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ss_n == 4'hF, "R1 selects high", ss_n, 4'hF);
        check(sclk == 1'b0, "R1 sclk low", sclk, 0);
        check(done == 1'b0, "R1 done low", done, 0);
        check(rx_byte == 8'h00, "R1 rx zero", rx_byte, 0);
    endtask

    // One transfer with the bench acting as the selected slave
    task automatic t_xfer(input logic [1:0] md, input logic [1:0] ix, input logic [7:0] dv,
                          input logic [7:0] txb, input logic [7:0] sb, input bit disturb);
        int h, cyc, edges, last, first_gap, nsent, gap_bad;
        logic prev;
        logic [7:0] mcap;
        logic [3:0] exp_ss;
        bit ss_bad, fin;
        string ptag;
        h = (dv == 0) ? 2 : int'(dv) + 1;
        exp_ss = ~(4'b0001 << ix);
        ptag = md[0] ? "R4" : "R3";

        @(negedge clk);
        mode = md; slave_idx = ix; divider = dv; tx_byte = txb; start = 1'b1;
        @(negedge clk);
        if (disturb) begin
            tx_byte = ~txb; slave_idx = ix + 2'd1; mode = ~md; divider = dv + 8'd3;
        end else begin
            start = 1'b0;
        end
        check(ss_n == exp_ss, "R6 select decoded", ss_n, exp_ss);
        check(sclk == md[1], "R2 sclk at idle level", sclk, md[1]);
        check(mosi == txb[7], {ptag, " first bit on select"}, mosi, txb[7]);

        miso = sb[7]; nsent = 1; prev = sclk;
        cyc = 0; edges = 0; last = 0; first_gap = -1; gap_bad = 0;
        mcap = '0; ss_bad = 0; fin = 0;
        while (!fin && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) start = 1'b0;
            if (done) begin
                fin = 1;
            end else begin
                if (ss_n != exp_ss) ss_bad = 1;
                if (sclk != prev) begin
                    edges++;
                    if (edges == 1) first_gap = cyc;
                    else if (cyc - last != h) gap_bad++;
                    last = cyc;
                    prev = sclk;
                    if (md[0] ? (edges % 2 == 0) : (edges % 2 == 1))
                        mcap = {mcap[6:0], mosi};
                    if ((md[0] && edges % 2 == 1 && edges > 1) ||
                        (!md[0] && edges % 2 == 0 && edges < 16)) begin
                        if (nsent < 8) miso = sb[7 - nsent];
                        nsent++;
                    end
                end
            end
        end
        check(fin, "R8 done seen", fin, 1);
        check(!ss_bad, "R6 select held for transfer", ss_bad, 0);
        check(first_gap == h, "R7 select-to-first-edge", first_gap, h);
        check(gap_bad == 0, "R7 edge spacing", gap_bad, 0);
        check(cyc - last == h, "R7 last-edge-to-release", cyc - last, h);
        check(edges == 16, "R10 edge count", edges, 16);
        check(mcap == txb, {ptag, " R5 mosi word MSB first"}, mcap, txb);
        check(rx_byte == sb, {ptag, " R5 received word"}, rx_byte, sb);
        check(ss_n == 4'hF, "R8 select released with done", ss_n, 4'hF);
        check(sclk == md[1], "R2 sclk back at idle", sclk, md[1]);
        if (disturb) check(edges == 16 && mcap == txb, "R11 R9 latched config", mcap, txb);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(rx_byte == sb, "R8 rx held", rx_byte, sb);
        check(ss_n == 4'hF, "R9 no restart after ignored start", ss_n, 4'hF);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_xfer(2'd0, 2'd0, 8'd1, 8'hA5, 8'h3C, 0);   // mode 0
        t_xfer(2'd1, 2'd1, 8'd2, 8'h81, 8'h7E, 0);   // mode 1
        t_xfer(2'd2, 2'd2, 8'd3, 8'hFF, 8'h00, 0);   // mode 2
        t_xfer(2'd3, 2'd3, 8'd1, 8'h00, 8'hFF, 0);   // mode 3
        t_xfer(2'd0, 2'd2, 8'd0, 8'h5A, 8'hC3, 0);   // divider 0 -> H = 2
        t_xfer(2'd1, 2'd1, 8'd4, 8'h96, 8'h69, 1);   // start and inputs disturbed
        t_xfer(2'd2, 2'd0, 8'd2, 8'h12, 8'hED, 1);
        t_xfer(2'd3, 2'd3, 8'd5, 8'hC0, 8'h03, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule